// File: doc/BRIEF.md
# Immediate Extension Prefix Decoder

This block sits between instruction fetch and execute in a processor with 16-bit instruction words and 32-bit data. It watches a stream of already-classified instructions. Any instruction marked as an extension prefix carries a 13-bit payload. The block holds up to two such payloads in order.

When the next non-prefix instruction arrives, the block builds that instruction's final 32-bit operand. It joins the held payloads with the instruction's own short field. The first prefix supplies the most significant part, the second prefix supplies the next 13 bits, and the instruction's field supplies the low bits. For some instructions the prefixes also change the form of the instruction. A post-increment register-indirect access becomes a register-plus-displacement access. A two-operand register-register operation becomes a three-operand operation with an immediate. The block reports this through a form flag, so that execute can pick the right datapath.

Results appear one clock after the target instruction is accepted. The held prefix state is cleared when the target is consumed, and also on a flush, so that a partial extension never reaches an unrelated instruction.

Top module: `ext_prefix_decoder`

## Requirements
- R1: An accepted prefix (kind 0) produces no result. Any other accepted kind produces exactly one result on the next clock, with `out_valid` high for that cycle.
- R2: Unsigned immediate (kind 1). With zero prefixes, the operand is `field[5:0]` zero-extended. With one prefix it is `{p1, field[5:0]}` zero-extended (19 bits). With two prefixes it is `{p1, p2, field[5:0]}` (32 bits).
- R3: Signed immediate (kind 2). Uses the same assembly as R2, but the 6-bit and 19-bit values are sign-extended from their top bit.
- R4: PC-relative branch (kind 3). The offset counts 2-byte instructions and is signed. The offset values are:
  - zero prefixes: `field[7:0]` (8 bits);
  - one prefix: `{p1, field[7:0]}` (21 bits);
  - two prefixes: `{p1[9:0], p2, field[7:0]}` (31 bits).
  The operand is `in_pc + (offset << 1)`, modulo 2^32.
- R5: Post-increment access (kind 4). With zero prefixes, the operand is 0 and `out_ext_form` is 0. With one prefix the operand is `p1` zero-extended; with two it is `{p1, p2}` zero-extended. In both prefixed cases `out_ext_form` is 1, which selects the non-incrementing displacement form.
- R6: SP displacement (kind 5). With zero prefixes, the operand is `field[5:0]` shifted left by the access size `in_size`: 0 is byte (×1), 1 is halfword (×2), 2 or 3 is word (×4). With one or two prefixes, the operand is the unscaled R2 value.
- R7: Register-register operation (kind 6). With zero prefixes, the operand is 0 and `out_ext_form` is 0. With one or two prefixes, the operand is built as in R5 and `out_ext_form` is 1, which selects the three-operand form. Kind 7 always yields operand 0 and `out_ext_form` 0.
- R8: Once a target has been consumed, the next target sees zero prefixes. `out_prefixes` reports how many prefixes the current result used.
- R9: `flush` discards all held prefixes and also drops any instruction presented in the same cycle.
- R10: A prefix that arrives while two are already held is illegal. `out_err` pulses on the next clock, and the held payloads stay unchanged.
- R11: During and right after reset, `out_valid` and `out_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard held prefixes and the current instruction |
| in_valid | input | 1 | Instruction present this cycle |
| in_kind | input | 3 | Instruction class (0 to 7, see requirements) |
| in_field | input | 13 | Prefix payload, or the short field in its low bits |
| in_size | input | 2 | Access size for SP displacement |
| in_pc | input | 32 | Address of the target instruction |
| out_valid | output | 1 | Result present |
| out_operand | output | 32 | Assembled operand or branch target |
| out_ext_form | output | 1 | Extended form selected |
| out_prefixes | output | 2 | Number of prefixes used by this result |
| out_err | output | 1 | Third-prefix error pulse |

## Verification
The assertions assume that `in_kind` and `flush` are always at known values and that inputs change only between clock edges. The bench meets this by driving every input on the falling edge, and by setting `in_valid` low with a legal kind whenever it is idle. The properties treat a flush as having priority over a coincident instruction. The stimulus includes such a coincidence, so the dropped instruction's missing result is observed.

// File: rtl/ext_pfx_pkg.sv
package ext_pfx_pkg;
   typedef enum logic [2:0] {
      K_PREFIX  = 3'd0,
      K_IMM_U   = 3'd1,
      K_IMM_S   = 3'd2,
      K_BRANCH  = 3'd3,
      K_POSTINC = 3'd4,
      K_SP_DISP = 3'd5,
      K_REGREG  = 3'd6,
      K_PLAIN   = 3'd7
   } ikind_t;
endpackage

// File: rtl/ext_pfx_accum.sv
module ext_pfx_accum #(
   parameter int PAY_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             take,
   input  logic             is_prefix,
   input  logic [PAY_W-1:0] payload,
   output logic [1:0]       cnt,
   output logic [PAY_W-1:0] p_hi,
   output logic [PAY_W-1:0] p_lo,
   output logic             full
);
   assign full = (cnt == 2'd2);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         p_hi <= '0;
         p_lo <= '0;
      end else if (flush) begin
         cnt <= '0;
      end else if (take) begin
         if (is_prefix) begin
            if (cnt == 2'd0) begin
               p_hi <= payload;
               cnt  <= 2'd1;
            end else if (cnt == 2'd1) begin
               p_lo <= payload;
               cnt  <= 2'd2;
            end
         end else begin
            cnt <= '0;
         end
      end
   end
endmodule

// File: rtl/ext_pfx_assemble.sv
module ext_pfx_assemble
   import ext_pfx_pkg::*;
#(
   parameter int PAY_W    = 13,
   parameter int SHORT_W  = 6,
   parameter int BR_W     = 8,
   parameter int BR2_W    = 31,
   parameter int DATA_W   = 32,
   parameter bit PC_ADD   = 1'b1,
   parameter bit SCALE_SP = 1'b1,
   parameter int LOW_W    = (SHORT_W > BR_W) ? SHORT_W : BR_W
) (
   input  ikind_t            kind,
   input  logic [LOW_W-1:0]  low_field,
   input  logic [1:0]        size,
   input  logic [DATA_W-1:0] pc,
   input  logic [1:0]        cnt,
   input  logic [PAY_W-1:0]  p_hi,
   input  logic [PAY_W-1:0]  p_lo,
   output logic [DATA_W-1:0] operand,
   output logic              ext_form
);
   localparam int IMM1_W = PAY_W + SHORT_W;
   localparam int BR1_W  = PAY_W + BR_W;
   localparam int HI_CUT = BR2_W - PAY_W - BR_W;

   function automatic logic [DATA_W-1:0] sx(input logic [DATA_W-1:0] v, input int w);
      logic signed [DATA_W-1:0] t;
      t = $signed(v << (DATA_W - w));
      return DATA_W'(t >>> (DATA_W - w));
   endfunction

   logic [SHORT_W-1:0] short_f;
   logic [BR_W-1:0]    br_f;
   logic [DATA_W-1:0]  u_imm, s_imm, br_off, br_res, sp_val, sp_base, disp_val;
   logic [1:0]         size_sh;

   assign short_f = low_field[SHORT_W-1:0];
   assign br_f    = low_field[BR_W-1:0];
   assign size_sh = (size == 2'd3) ? 2'd2 : size;

   always_comb begin
      case (cnt)
         2'd0:    u_imm = DATA_W'(short_f);
         2'd1:    u_imm = DATA_W'({p_hi, short_f});
         default: u_imm = DATA_W'({p_hi, p_lo, short_f});
      endcase
   end

   always_comb begin
      case (cnt)
         2'd0:    s_imm = sx(DATA_W'(short_f), SHORT_W);
         2'd1:    s_imm = sx(DATA_W'({p_hi, short_f}), IMM1_W);
         default: s_imm = u_imm;
      endcase
   end

   always_comb begin
      case (cnt)
         2'd0:    br_off = sx(DATA_W'(br_f), BR_W);
         2'd1:    br_off = sx(DATA_W'({p_hi, br_f}), BR1_W);
         default: br_off = sx(DATA_W'({p_hi[HI_CUT-1:0], p_lo, br_f}), BR2_W);
      endcase
   end

   always_comb begin
      case (cnt)
         2'd0:    disp_val = '0;
         2'd1:    disp_val = DATA_W'(p_hi);
         default: disp_val = DATA_W'({p_hi, p_lo});
      endcase
   end

   generate
      if (PC_ADD) begin : g_pc_add
         assign br_res = pc + (br_off << 1);
      end else begin : g_pc_off
         assign br_res = br_off << 1;
      end
      if (SCALE_SP) begin : g_sp_scale
         assign sp_base = DATA_W'(short_f) << size_sh;
      end else begin : g_sp_flat
         assign sp_base = DATA_W'(short_f);
      end
   endgenerate

   assign sp_val = (cnt == 2'd0) ? sp_base : u_imm;

   always_comb begin
      case (kind)
         K_IMM_U:   operand = u_imm;
         K_IMM_S:   operand = s_imm;
         K_BRANCH:  operand = br_res;
         K_POSTINC: operand = disp_val;
         K_REGREG:  operand = disp_val;
         K_SP_DISP: operand = sp_val;
         default:   operand = '0;
      endcase
   end

   assign ext_form = ((kind == K_POSTINC) || (kind == K_REGREG)) && (cnt != 2'd0);
endmodule

// File: rtl/ext_prefix_decoder.sv
module ext_prefix_decoder
   import ext_pfx_pkg::*;
#(
   parameter int PAY_W    = 13,
   parameter int SHORT_W  = 6,
   parameter int BR_W     = 8,
   parameter int BR2_W    = 31,
   parameter int DATA_W   = 32,
   parameter bit PC_ADD   = 1'b1,
   parameter bit SCALE_SP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              in_valid,
   input  logic [2:0]        in_kind,
   input  logic [PAY_W-1:0]  in_field,
   input  logic [1:0]        in_size,
   input  logic [DATA_W-1:0] in_pc,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_operand,
   output logic              out_ext_form,
   output logic [1:0]        out_prefixes,
   output logic              out_err
);
   localparam int LOW_W = (SHORT_W > BR_W) ? SHORT_W : BR_W;

   generate
      if (2 * PAY_W + SHORT_W != DATA_W) begin : g_bad_imm
         $error("two payloads plus the short field must fill the data width");
      end
      if (BR2_W <= PAY_W + BR_W || BR2_W > 2 * PAY_W + BR_W || BR2_W >= DATA_W) begin : g_bad_br
         $error("widest branch offset width out of range");
      end
      if (LOW_W > PAY_W) begin : g_bad_low
         $error("short fields must fit within the payload width");
      end
   endgenerate

   ikind_t             kind;
   logic               is_prefix, take, full;
   logic [1:0]         pend_cnt;
   logic [PAY_W-1:0]   p_hi, p_lo;
   logic [DATA_W-1:0]  operand_c;
   logic               ext_c;

   assign kind      = ikind_t'(in_kind);
   assign is_prefix = (kind == K_PREFIX);
   assign take      = in_valid && !flush;

   ext_pfx_accum #(.PAY_W(PAY_W)) u_accum (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .take      (in_valid),
      .is_prefix (is_prefix),
      .payload   (in_field),
      .cnt       (pend_cnt),
      .p_hi      (p_hi),
      .p_lo      (p_lo),
      .full      (full)
   );

   ext_pfx_assemble #(
      .PAY_W    (PAY_W),
      .SHORT_W  (SHORT_W),
      .BR_W     (BR_W),
      .BR2_W    (BR2_W),
      .DATA_W   (DATA_W),
      .PC_ADD   (PC_ADD),
      .SCALE_SP (SCALE_SP),
      .LOW_W    (LOW_W)
   ) u_asm (
      .kind      (kind),
      .low_field (in_field[LOW_W-1:0]),
      .size      (in_size),
      .pc        (in_pc),
      .cnt       (pend_cnt),
      .p_hi      (p_hi),
      .p_lo      (p_lo),
      .operand   (operand_c),
      .ext_form  (ext_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_operand  <= '0;
         out_ext_form <= 1'b0;
         out_prefixes <= '0;
         out_err      <= 1'b0;
      end else begin
         out_valid <= take && !is_prefix;
         out_err   <= take && is_prefix && full;
         if (take && !is_prefix) begin
            out_operand  <= operand_c;
            out_ext_form <= ext_c;
            out_prefixes <= pend_cnt;
         end
      end
   end
endmodule

// File: rtl/ext_pfx_checker.sv
module ext_pfx_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       flush,
   input logic       in_valid,
   input logic [2:0] in_kind,
   input logic       out_valid,
   input logic       out_ext_form,
   input logic [1:0] out_prefixes,
   input logic       out_err,
   input logic [1:0] pend_cnt
);
   logic acc_pfx, acc_tgt;
   assign acc_pfx = in_valid && !flush && (in_kind == 3'd0);
   assign acc_tgt = in_valid && !flush && (in_kind != 3'd0);

   assert_prefix_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
      acc_pfx |=> !out_valid);
   assert_target_emits_R1: assert property (@(posedge clk) disable iff (!rst_n)
      acc_tgt |=> out_valid);
   assert_clear_after_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_tgt |=> (pend_cnt == 2'd0));
   assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (pend_cnt == 2'd0 && !out_valid));
   assert_no_err_below_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_pfx && pend_cnt != 2'd2) |=> !out_err);
   assert_err_keeps_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_pfx && pend_cnt == 2'd2) |=> (out_err && pend_cnt == 2'd2));
   assert_cnt_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pend_cnt != 2'd3);
   assert_base_form_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_prefixes == 2'd0) |-> !out_ext_form);
endmodule

bind ext_prefix_decoder ext_pfx_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .flush        (flush),
   .in_valid     (in_valid),
   .in_kind      (in_kind),
   .out_valid    (out_valid),
   .out_ext_form (out_ext_form),
   .out_prefixes (out_prefixes),
   .out_err      (out_err),
   .pend_cnt     (pend_cnt)
);

// File: tb/ext_prefix_decoder_test.sv
module ext_prefix_decoder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  in_kind = 3'd7;
   logic [12:0] in_field = '0;
   logic [1:0]  in_size = '0;
   logic [31:0] in_pc = '0;
   logic        out_valid, out_ext_form, out_err;
   logic [31:0] out_operand;
   logic [1:0]  out_prefixes;

   always #4 clk = ~clk;

   ext_prefix_decoder uut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
      .in_kind(in_kind), .in_field(in_field), .in_size(in_size), .in_pc(in_pc),
      .out_valid(out_valid), .out_operand(out_operand), .out_ext_form(out_ext_form),
      .out_prefixes(out_prefixes), .out_err(out_err)
   );

   typedef struct {
      logic [31:0] op;
      logic        ext;
      logic [1:0]  pfx;
      string       tag;
   } exp_t;

   exp_t  exp_q[$];
   string err_q[$];
   int    checks = 0;
   int    fails = 0;
   bit    done = 1'b0;
   int    m_cnt = 0;
   logic [12:0] m_p1 = '0, m_p2 = '0;

   function automatic logic [31:0] sx(input logic [31:0] v, input int w);
      logic signed [31:0] t;
      t = $signed(v << (32 - w));
      return 32'(t >>> (32 - w));
   endfunction

   function automatic logic [31:0] model_op(input logic [2:0] k, input logic [12:0] f,
         input logic [1:0] sz, input logic [31:0] pc, input int n,
         input logic [12:0] p1, input logic [12:0] p2);
      logic [31:0] u, off;
      if (n == 0) u = {26'd0, f[5:0]};
      else if (n == 1) u = {13'd0, p1, f[5:0]};
      else u = {p1, p2, f[5:0]};
      case (k)
         3'd1: return u;
         3'd2: return (n == 0) ? sx(u, 6) : (n == 1) ? sx(u, 19) : u;
         3'd3: begin
            if (n == 0) off = sx({24'd0, f[7:0]}, 8);
            else if (n == 1) off = sx({11'd0, p1, f[7:0]}, 21);
            else off = sx({1'b0, p1[9:0], p2, f[7:0]}, 31);
            return pc + (off << 1);
         end
         3'd4, 3'd6: return (n == 0) ? 32'd0 : (n == 1) ? {19'd0, p1} : {6'd0, p1, p2};
         3'd5: return (n == 0) ? ({26'd0, f[5:0]} << ((sz == 2'd3) ? 2 : sz)) : u;
         default: return 32'd0;
      endcase
   endfunction

   task automatic send(input logic [2:0] k, input logic [12:0] f, input logic [1:0] sz,
                       input logic [31:0] pc, input logic fl, input string tag);
      exp_t e;
      @(negedge clk);
      in_valid = 1'b1; in_kind = k; in_field = f; in_size = sz; in_pc = pc; flush = fl;
      if (fl) begin
         m_cnt = 0;
      end else if (k == 3'd0) begin
         if (m_cnt == 2) err_q.push_back(tag);
         else if (m_cnt == 1) begin m_p2 = f; m_cnt = 2; end
         else begin m_p1 = f; m_cnt = 1; end
      end else begin
         e.op  = model_op(k, f, sz, pc, m_cnt, m_p1, m_p2);
         e.ext = ((k == 3'd4) || (k == 3'd6)) && (m_cnt != 0);
         e.pfx = 2'(m_cnt);
         e.tag = tag;
         exp_q.push_back(e);
         m_cnt = 0;
      end
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0; in_kind = 3'd7; flush = 1'b0;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   // scoreboard monitor
   always @(posedge clk) begin
      #1;
      if (rst_n && out_valid) begin
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R1 unexpected result op=%h expected no result", out_operand);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (out_operand !== e.op || out_ext_form !== e.ext || out_prefixes !== e.pfx) begin
               fails++;
               $display("FAIL %s op=%h ext=%b pfx=%0d expected op=%h ext=%b pfx=%0d",
                        e.tag, out_operand, out_ext_form, out_prefixes, e.op, e.ext, e.pfx);
            end
         end
      end
      if (rst_n && out_err) begin
         checks++;
         if (err_q.size() == 0) begin
            fails++;
            $display("FAIL R10 out_err=1 expected 0");
         end else void'(err_q.pop_front());
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL R1 watchdog expired: run did not complete, expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || out_err !== 1'b0) begin
         fails++;
         $display("FAIL R11 during reset valid=%b err=%b expected 0 0", out_valid, out_err);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || out_err !== 1'b0) begin
         fails++;
         $display("FAIL R11 after reset valid=%b err=%b expected 0 0", out_valid, out_err);
      end

      // R2 unsigned immediate
      send(3'd1, 13'h002A, 2'd0, 32'h0, 1'b0, "R2");
      send(3'd0, 13'h1ABC, 2'd0, 32'h0, 1'b0, "R2");
      send(3'd1, 13'h0015, 2'd0, 32'h0, 1'b0, "R2");
      send(3'd0, 13'h1FFF, 2'd0, 32'h0, 1'b0, "R2");
      send(3'd0, 13'h0123, 2'd0, 32'h0, 1'b0, "R2");
      send(3'd1, 13'h003F, 2'd0, 32'h0, 1'b0, "R2");
      // R3 signed immediate
      send(3'd2, 13'h0020, 2'd0, 32'h0, 1'b0, "R3");
      send(3'd2, 13'h001F, 2'd0, 32'h0, 1'b0, "R3");
      send(3'd0, 13'h1000, 2'd0, 32'h0, 1'b0, "R3");
      send(3'd2, 13'h0001, 2'd0, 32'h0, 1'b0, "R3");
      send(3'd0, 13'h1F00, 2'd0, 32'h0, 1'b0, "R3");
      send(3'd0, 13'h0000, 2'd0, 32'h0, 1'b0, "R3");
      send(3'd2, 13'h0030, 2'd0, 32'h0, 1'b0, "R3");
      // R4 branches
      send(3'd3, 13'h0080, 2'd0, 32'h0000_1000, 1'b0, "R4");
      send(3'd3, 13'h007F, 2'd0, 32'h0000_1000, 1'b0, "R4");
      send(3'd0, 13'h1000, 2'd0, 32'h0, 1'b0, "R4");
      send(3'd3, 13'h0000, 2'd0, 32'h0040_0000, 1'b0, "R4");
      send(3'd0, 13'h1FFF, 2'd0, 32'h0, 1'b0, "R4");
      send(3'd0, 13'h1FFF, 2'd0, 32'h0, 1'b0, "R4");
      send(3'd3, 13'h00FE, 2'd0, 32'h0000_0100, 1'b0, "R4");
      send(3'd0, 13'h1C01, 2'd0, 32'h0, 1'b0, "R4");
      send(3'd0, 13'h0002, 2'd0, 32'h0, 1'b0, "R4");
      send(3'd3, 13'h0003, 2'd0, 32'h0000_0010, 1'b0, "R4");
      // R5 post-increment to displacement
      send(3'd4, 13'h0015, 2'd0, 32'h0, 1'b0, "R5");
      send(3'd0, 13'h0ABC, 2'd0, 32'h0, 1'b0, "R5");
      send(3'd4, 13'h0000, 2'd0, 32'h0, 1'b0, "R5");
      send(3'd0, 13'h1234, 2'd0, 32'h0, 1'b0, "R5");
      send(3'd0, 13'h0567, 2'd0, 32'h0, 1'b0, "R5");
      send(3'd4, 13'h0000, 2'd0, 32'h0, 1'b0, "R5");
      // R6 SP displacement
      send(3'd5, 13'h003F, 2'd0, 32'h0, 1'b0, "R6");
      send(3'd5, 13'h003F, 2'd1, 32'h0, 1'b0, "R6");
      send(3'd5, 13'h003F, 2'd2, 32'h0, 1'b0, "R6");
      send(3'd5, 13'h0011, 2'd3, 32'h0, 1'b0, "R6");
      send(3'd0, 13'h0003, 2'd0, 32'h0, 1'b0, "R6");
      send(3'd5, 13'h0005, 2'd2, 32'h0, 1'b0, "R6");
      // R7 register-register
      send(3'd6, 13'h0009, 2'd0, 32'h0, 1'b0, "R7");
      send(3'd0, 13'h1111, 2'd0, 32'h0, 1'b0, "R7");
      send(3'd6, 13'h0000, 2'd0, 32'h0, 1'b0, "R7");
      send(3'd0, 13'h0F0F, 2'd0, 32'h0, 1'b0, "R7");
      send(3'd0, 13'h10F0, 2'd0, 32'h0, 1'b0, "R7");
      send(3'd6, 13'h0000, 2'd0, 32'h0, 1'b0, "R7");
      send(3'd0, 13'h0777, 2'd0, 32'h0, 1'b0, "R7");
      send(3'd7, 13'h003F, 2'd0, 32'h0, 1'b0, "R7");
      // R8 state cleared after target
      send(3'd1, 13'h0007, 2'd0, 32'h0, 1'b0, "R8");
      idle();
      // R9 flush
      send(3'd0, 13'h1555, 2'd0, 32'h0, 1'b0, "R9");
      send(3'd1, 13'h0001, 2'd0, 32'h0, 1'b1, "R9");
      send(3'd1, 13'h0002, 2'd0, 32'h0, 1'b0, "R9");
      send(3'd0, 13'h0AAA, 2'd0, 32'h0, 1'b0, "R9");
      send(3'd0, 13'h0BBB, 2'd0, 32'h0, 1'b1, "R9");
      send(3'd6, 13'h0000, 2'd0, 32'h0, 1'b0, "R9");
      // R10 third prefix
      send(3'd0, 13'h0001, 2'd0, 32'h0, 1'b0, "R10");
      send(3'd0, 13'h0002, 2'd0, 32'h0, 1'b0, "R10");
      send(3'd0, 13'h1FFF, 2'd0, 32'h0, 1'b0, "R10");
      send(3'd1, 13'h0004, 2'd0, 32'h0, 1'b0, "R10");
      send(3'd1, 13'h0005, 2'd0, 32'h0, 1'b0, "R10");
      repeat (4) idle();

      checks++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL R1 results missing: %0d expected 0", exp_q.size());
      end
      checks++;
      if (err_q.size() != 0) begin
         fails++;
         $display("FAIL R10 error pulses missing: %0d expected 0", err_q.size());
      end
      done = 1'b1;
      summary();
      $finish;
   end
endmodule